// File: doc/BRIEF.md
# Flash Bulk-Erase Sequencer

This block is a host-side controller that carries out the full bulk-erase procedure on a command-driven parallel flash device. A single-cycle `start` pulse launches the run. First the controller asks a companion program sequencer to bring every byte to 00h, using a request/acknowledge handshake. It then writes the erase command twice: the first write arms the device and the second begins the erase. After that it waits out a fixed erase pulse time.

After the pulse, the controller verifies the array byte by byte. For each byte it writes the erase-verify command with the byte's address, strobes a read, and compares the returned byte against FFh. On a match it moves to the next address. On a mismatch it repeats the whole erase pulse and resumes verification at the address that failed. It stops at a hard ceiling on the number of erase pulses. In every case it leaves the device in read mode.

The device side is a plain strobe bus with no back-pressure. A write is one cycle of `bus_we`. A read is one cycle of `bus_re`, and the device returns `bus_rdata` in the following cycle, where the controller samples it. There is no streaming interface, so no valid/ready rules apply. The pulse length in clock cycles, the address width and the attempt ceiling are parameters.

Top module: `flash_erase_seq`

## Requirements
- R1: After `start` the block raises `pp_req` and holds it until it sees `pp_ack`. No bus strobe occurs before that, and the first erase pulse comes only after pre-programming.
- R2: Each erase attempt is two consecutive writes of code 20h at address 0. The first write arms the device and the second starts erasing.
- R3: The first erase-verify write after an erase-start write comes exactly PULSE_CYC+1 cycles after it.
- R4: Each verify step has three parts. First, one write of code A0h at the byte address. Next cycle, one read strobe at the same address. In the cycle after that, `bus_rdata` is compared with FFh.
- R5: When the byte matches, verification moves to the next address. When the last address (all ones) matches, the block writes code 00h at address 0. In the next cycle `done` is high for exactly one cycle and `busy` is low.
- R6: When a byte mismatches and the attempt ceiling has not been reached, a new two-write erase attempt follows. After the pulse, verification restarts at the failing address.
- R7: At most MAX_TRIES erase attempts are made. If a byte still mismatches after attempt MAX_TRIES, the block writes 00h at address 0, then drops `busy` and raises `fail`. `fail` stays high until the next `start`.
- R8: After reset, `busy`, `done`, `fail`, `pp_req`, `bus_we` and `bus_re` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to run the erase procedure (taken when idle) |
| busy | output | 1 | Procedure in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| fail | output | 1 | Attempt ceiling exhausted; held until next start |
| pp_req | output | 1 | Request to the program sequencer to zero the array |
| pp_ack | input | 1 | Pre-programming complete |
| bus_addr | output | ADDR_W | Device address |
| bus_wdata | output | 8 | Command byte to the device |
| bus_we | output | 1 | Write strobe, one cycle per write |
| bus_re | output | 1 | Read strobe; data returns next cycle |
| bus_rdata | input | 8 | Read data from the device |

## Verification
The bench uses a device model in which each byte reads FFh only after it has received a set number of erase pulses. This makes some bytes stubborn. With that model, a design that restarts verification at address 0 after a re-erase produces extra verify transactions, and a design that skips the failing byte misses transactions. A byte that needs exactly MAX_TRIES pulses checks the ceiling from the passing side, and one that needs one pulse more checks it from the failing side, so an off-by-one in the attempt counter either fails a good array or makes a 1001st attempt. The bench also measures the gap from each erase-start write to the first verify write, which catches a timer that is one cycle short or long. It checks that `fail` clears on the next `start`.

// File: rtl/fes_pkg.sv
package fes_pkg;
  localparam logic [7:0] CMD_ERASE  = 8'h20;
  localparam logic [7:0] CMD_VERIFY = 8'hA0;
  localparam logic [7:0] CMD_READ   = 8'h00;
  localparam logic [7:0] BYTE_BLANK = 8'hFF;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PREP, ST_ARM, ST_FIRE, ST_PULSE,
    ST_VWR, ST_VRD, ST_VCHK, ST_END_OK, ST_END_BAD
  } fes_state_t;
endpackage

// File: rtl/fes_pulse_timer.sv
module fes_pulse_timer #(
  parameter int PULSE_CYC = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expired
);
  localparam int TW = $clog2(PULSE_CYC + 1);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= TW'(PULSE_CYC - 1);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/fes_addr_walker.sv
module fes_addr_walker #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              inc,
  output logic [ADDR_W-1:0] addr,
  output logic              last
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) addr <= '0;
    else if (inc)      addr <= addr + 1'b1;
  end

  assign last = &addr;
endmodule

// File: rtl/fes_try_counter.sv
module fes_try_counter #(
  parameter int MAX_TRIES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic at_limit
);
  localparam int CW = $clog2(MAX_TRIES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt_q <= '0;
    else if (inc)      cnt_q <= cnt_q + 1'b1;
  end

  assign at_limit = (cnt_q == CW'(MAX_TRIES));
endmodule

// File: rtl/fes_ctrl.sv
module fes_ctrl
  import fes_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              pp_ack,
  input  logic              timer_expired,
  input  logic              addr_last,
  input  logic              tries_at_limit,
  input  logic [ADDR_W-1:0] vaddr,
  input  logic [7:0]        bus_rdata,
  output logic              pp_req,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [7:0]        bus_wdata,
  output logic              bus_we,
  output logic              bus_re,
  output logic              timer_load,
  output logic              addr_clr,
  output logic              addr_inc,
  output logic              try_clr,
  output logic              try_inc
);
  fes_state_t st_q, st_d;
  logic done_q, fail_q;

  always_comb begin
    st_d       = st_q;
    pp_req     = 1'b0;
    bus_addr   = '0;
    bus_wdata  = CMD_READ;
    bus_we     = 1'b0;
    bus_re     = 1'b0;
    timer_load = 1'b0;
    addr_clr   = 1'b0;
    addr_inc   = 1'b0;
    try_clr    = 1'b0;
    try_inc    = 1'b0;
    case (st_q)
      ST_IDLE: if (start) begin
        st_d     = ST_PREP;
        addr_clr = 1'b1;
        try_clr  = 1'b1;
      end
      ST_PREP: begin
        pp_req = 1'b1;
        if (pp_ack) st_d = ST_ARM;
      end
      ST_ARM: begin
        bus_we    = 1'b1;
        bus_wdata = CMD_ERASE;
        st_d      = ST_FIRE;
      end
      ST_FIRE: begin
        bus_we     = 1'b1;
        bus_wdata  = CMD_ERASE;
        timer_load = 1'b1;
        try_inc    = 1'b1;
        st_d       = ST_PULSE;
      end
      ST_PULSE: if (timer_expired) st_d = ST_VWR;
      ST_VWR: begin
        bus_we    = 1'b1;
        bus_wdata = CMD_VERIFY;
        bus_addr  = vaddr;
        st_d      = ST_VRD;
      end
      ST_VRD: begin
        bus_re   = 1'b1;
        bus_addr = vaddr;
        st_d     = ST_VCHK;
      end
      ST_VCHK: begin
        if (bus_rdata == BYTE_BLANK) begin
          if (addr_last) st_d = ST_END_OK;
          else begin
            addr_inc = 1'b1;
            st_d     = ST_VWR;
          end
        end else if (tries_at_limit) st_d = ST_END_BAD;
        else                         st_d = ST_ARM;
      end
      ST_END_OK, ST_END_BAD: begin
        bus_we    = 1'b1;
        bus_wdata = CMD_READ;
        st_d      = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= (st_q == ST_END_OK);
      if (st_q == ST_END_BAD)               fail_q <= 1'b1;
      else if (st_q == ST_IDLE && start)    fail_q <= 1'b0;
    end
  end

  assign busy = (st_q != ST_IDLE);
  assign done = done_q;
  assign fail = fail_q;
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq #(
  parameter int ADDR_W    = 4,
  parameter int PULSE_CYC = 40,
  parameter int MAX_TRIES = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic              pp_req,
  input  logic              pp_ack,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [7:0]        bus_wdata,
  output logic              bus_we,
  output logic              bus_re,
  input  logic [7:0]        bus_rdata
);
  logic timer_load, timer_expired;
  logic addr_clr, addr_inc, addr_last;
  logic try_clr, try_inc, tries_at_limit;
  logic [ADDR_W-1:0] vaddr;

  fes_pulse_timer #(.PULSE_CYC(PULSE_CYC)) timer_i (
    .clk(clk), .rst_n(rst_n), .load(timer_load), .expired(timer_expired)
  );

  fes_addr_walker #(.ADDR_W(ADDR_W)) walk_i (
    .clk(clk), .rst_n(rst_n), .clr(addr_clr), .inc(addr_inc),
    .addr(vaddr), .last(addr_last)
  );

  fes_try_counter #(.MAX_TRIES(MAX_TRIES)) tries_i (
    .clk(clk), .rst_n(rst_n), .clr(try_clr), .inc(try_inc),
    .at_limit(tries_at_limit)
  );

  fes_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start(start), .pp_ack(pp_ack),
    .timer_expired(timer_expired), .addr_last(addr_last),
    .tries_at_limit(tries_at_limit), .vaddr(vaddr), .bus_rdata(bus_rdata),
    .pp_req(pp_req), .busy(busy), .done(done), .fail(fail),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
    .bus_re(bus_re), .timer_load(timer_load), .addr_clr(addr_clr),
    .addr_inc(addr_inc), .try_clr(try_clr), .try_inc(try_inc)
  );
endmodule

// File: rtl/fes_checker.sv
module fes_checker
  import fes_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int PULSE_CYC = 40,
  parameter int MAX_TRIES = 1000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              fail,
  input logic              pp_req,
  input logic              pp_ack,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_wdata,
  input logic              bus_we,
  input logic              bus_re,
  input logic [7:0]        bus_rdata
);
  logic        half_q;
  logic        armed_q;
  int unsigned gap_q;
  int unsigned fires_q;
  logic        fire_now, verify_now;

  assign fire_now   = bus_we && bus_wdata == CMD_ERASE && half_q;
  assign verify_now = bus_we && bus_wdata == CMD_VERIFY;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      half_q  <= 1'b0;
      armed_q <= 1'b0;
      gap_q   <= 0;
      fires_q <= 0;
    end else begin
      if (bus_we) half_q <= (bus_wdata == CMD_ERASE) ? !half_q : 1'b0;
      if (fire_now)        armed_q <= 1'b1;
      else if (verify_now) armed_q <= 1'b0;
      if (fire_now)                  gap_q <= 1;
      else if (gap_q < 32'hFFFF_0000) gap_q <= gap_q + 1;
      if (start && !busy)  fires_q <= 0;
      else if (fire_now)   fires_q <= fires_q + 1;
    end
  end

  // R1
  pp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pp_req |-> !bus_we && !bus_re);

  // R3
  pulse_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && verify_now) |-> gap_q == PULSE_CYC + 1);

  // R4
  verify_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    verify_now |=> bus_re && bus_addr == $past(bus_addr));

  // R7
  try_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fires_q <= MAX_TRIES);

  // R7
  fail_at_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> fires_q == MAX_TRIES && !busy);

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  done_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !fail && $past(bus_we) && $past(bus_wdata) == CMD_READ);
endmodule

bind flash_erase_seq fes_checker #(
  .ADDR_W(ADDR_W), .PULSE_CYC(PULSE_CYC), .MAX_TRIES(MAX_TRIES)
) chk_i (.*);

// File: tb/flash_erase_seq_tb_top.sv
`timescale 1ns/1ps
module flash_erase_seq_tb_top;
  localparam int ADDR_W    = 4;
  localparam int PULSE_CYC = 40;
  localparam int MAX_TRIES = 1000;
  localparam int DEPTH     = 1 << ADDR_W;
  localparam int IW        = ADDR_W + 9;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0, pp_ack = 1'b0;
  logic busy, done, fail, pp_req, bus_we, bus_re;
  logic [ADDR_W-1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata = 8'h00;

  flash_erase_seq #(.ADDR_W(ADDR_W), .PULSE_CYC(PULSE_CYC), .MAX_TRIES(MAX_TRIES)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .fail(fail),
    .pp_req(pp_req), .pp_ack(pp_ack), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata)
  );

  int vectors = 0, miscompares = 0;
  int need [DEPTH];
  int erases = 0, ack_dly = 0;
  logic setup_seen = 1'b0, preprog = 1'b0, bad_order = 1'b0;

  // device model: a byte reads FFh once it has had need[] erase pulses
  always @(posedge clk) begin
    if (start && !busy) begin
      erases <= 0; preprog <= 1'b0; setup_seen <= 1'b0; bad_order <= 1'b0;
    end else begin
      if (bus_re) bus_rdata <= (erases >= need[bus_addr]) ? 8'hFF : 8'h00;
      if (bus_we) begin
        if (bus_wdata == 8'h20) begin
          if (setup_seen) begin
            erases <= erases + 1; setup_seen <= 1'b0;
            if (!preprog) bad_order <= 1'b1;
          end else setup_seen <= 1'b1;
        end else setup_seen <= 1'b0;
      end
    end
    if (pp_req && !pp_ack) begin
      if (ack_dly == 3) begin pp_ack <= 1'b1; preprog <= 1'b1; ack_dly <= 0; end
      else ack_dly <= ack_dly + 1;
    end else pp_ack <= 1'b0;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // scoreboard
  logic [IW-1:0] expq[$];
  int exp_tries;
  bit exp_ok;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [IW-1:0] mk(input bit rd, input int a, input logic [7:0] d);
    return {rd, ADDR_W'(a), d};
  endfunction

  task automatic build_expected();
    int tries = 0, a = 0;
    exp_ok = 1'b0;
    expq.delete();
    forever begin
      expq.push_back(mk(1'b0, 0, 8'h20));
      expq.push_back(mk(1'b0, 0, 8'h20));
      tries++;
      while (a < DEPTH) begin
        expq.push_back(mk(1'b0, a, 8'hA0));
        expq.push_back(mk(1'b1, a, 8'h00));
        if (tries >= need[a]) a++;
        else break;
      end
      if (a == DEPTH) begin exp_ok = 1'b1; break; end
      if (tries == MAX_TRIES) break;
    end
    expq.push_back(mk(1'b0, 0, 8'h00));
    exp_tries = tries;
  endtask

  // monitor
  logic mon_half = 1'b0, mon_armed = 1'b0;
  int fire_cyc = 0;
  always @(negedge clk) begin
    if (rst_n && (bus_we || bus_re)) begin
      logic [IW-1:0] got, want;
      got = {bus_re, bus_addr, bus_re ? 8'h00 : bus_wdata};
      if (expq.size() == 0) chk(1'b0, "R6", "unexpected bus transaction", int'(got), -1);
      else begin
        want = expq.pop_front();
        chk(got == want, "R2/R4/R6", "bus transaction", int'(got), int'(want));
      end
      if (bus_we && bus_wdata == 8'h20) begin
        if (mon_half) begin fire_cyc = cyc; mon_armed = 1'b1; end
        mon_half = !mon_half;
      end else if (bus_we) begin
        mon_half = 1'b0;
        if (bus_wdata == 8'hA0 && mon_armed) begin
          chk(cyc - fire_cyc == PULSE_CYC + 1, "R3", "pulse gap", cyc - fire_cyc, PULSE_CYC + 1);
          mon_armed = 1'b0;
        end
      end
    end
  end

  task automatic run_case(input string name);
    build_expected();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(busy && !fail, "R7", {name, " busy set, fail cleared on start"}, int'({busy, fail}), 2);
    while (busy) @(negedge clk);
    chk(done == exp_ok, "R5", {name, " done at busy drop"}, int'(done), int'(exp_ok));
    chk(fail == !exp_ok, "R7", {name, " fail at busy drop"}, int'(fail), int'(!exp_ok));
    chk(erases == exp_tries, "R6", {name, " erase attempts"}, erases, exp_tries);
    chk(!bad_order, "R1", {name, " erase before pre-program"}, int'(bad_order), 0);
    @(negedge clk);
    chk(expq.size() == 0, "R5", {name, " leftover transactions"}, expq.size(), 0);
    chk(!done, "R5", {name, " done one cycle"}, int'(done), 0);
    chk(fail == !exp_ok, "R7", {name, " fail held"}, int'(fail), int'(!exp_ok));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) need[i] = 1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, done, fail, pp_req, bus_we, bus_re} == 6'b0, "R8", "reset outputs",
        int'({busy, done, fail, pp_req, bus_we, bus_re}), 0);

    run_case("single-pass");

    need[5] = 3; need[15] = 2;
    run_case("stubborn-bytes");

    for (int i = 0; i < DEPTH; i++) need[i] = 1;
    need[3] = MAX_TRIES;
    run_case("pass-at-ceiling");

    need[3] = 1; need[7] = MAX_TRIES + 1;
    run_case("exceed-ceiling");

    for (int i = 0; i < DEPTH; i++) need[i] = 1;
    need[0] = 2;
    run_case("recover-after-fail");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule